// File: doc/BRIEF.md
# UART Data and Error Status Front End

This block sits between a byte-wide processor bus and the serial shift engines of one UART channel. On the transmit side it holds a 9-bit word that software writes as two bytes. The upper byte goes first and arms the buffer. The lower byte then commits the whole word to the serial core with a one-cycle load strobe.

On the receive side it captures each completed 9-bit word together with its framing and parity status. Software reads the word as two bytes. The upper byte also carries the overrun, framing, parity and summary error flags, and reading it consumes the word. Any error flag is cleared when the receiver is switched off, either by its enable bit or by the all-zero mode value.

A programmable 8-bit divider turns the clock into a periodic one-cycle enable pulse for the baud logic.

Top module: `uart_reg_front`

## Requirements
- R1: With divider setting n (0 to 255), `baud_en_o` is a one-cycle pulse that repeats every n+1 clock cycles.
- R2: Writing a new divider setting does not restart the count in progress. The next pulse keeps the old schedule, and the new period applies from the reload that follows.
- R3: A write to the transmit high byte (address 1; only bit 0 is kept) followed by a write to the transmit low byte (address 0) produces exactly one `tx_load_o` pulse. During that pulse, `tx_data_o` equals {high bit 0, low byte}.
- R4: A transmit low-byte write with no high-byte write since the last commit produces no `tx_load_o` pulse.
- R5: A read of address 2 returns received bits 7..0. A read of address 3 returns received bit 8 in bit 0, and 0 in bits 3..1.
- R6: In the address-3 byte, bit 4 is overrun, bit 5 is framing, bit 6 is parity and bit 7 is the summary. A value of 1 means an error. Framing and parity are taken from the core's status at the receive-complete strobe.
- R7: A read of address 3 clears the framing and parity flags and leaves the overrun flag unchanged.
- R8: A receive-complete strobe that arrives before the previous word has been consumed by an address-3 read sets overrun. The previous data and flags are kept.
- R9: The summary flag is 1 whenever any of overrun, framing or parity is 1. It returns to 0 only once all three are 0.
- R10: While `rx_en_i` is 0 or `mode_i` is 000b, all four error flags read 0 and receive-complete strobes are ignored. The last received data is kept.
- R11: After reset, the error flags are 0, no transmit load is issued, and the divider setting is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select: 0 tx low, 1 tx high, 2 rx low, 3 rx high/status, 4 divider |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe (address 3 read has side effects) |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data, 0 when no read is active |
| mode_i | input | 3 | Channel mode; 000b means interface disabled |
| rx_en_i | input | 1 | Receiver enable |
| rx_done_i | input | 1 | Receive-complete strobe from the serial core |
| rx_data_i | input | 9 | Received word |
| rx_fer_i | input | 1 | Framing error of the received word |
| rx_per_i | input | 1 | Parity error of the received word |
| tx_load_o | output | 1 | One-cycle transmit load strobe to the serial core |
| tx_data_o | output | 9 | Transmit word presented with the load strobe |
| baud_en_o | output | 1 | Baud clock enable pulse |

## Verification
Four rules are checked on every cycle by assertions:
- Flags clear when the receiver is off.
- A status read clears framing and parity but not overrun.
- An overrun keeps the old word.
- The divider emits isolated pulses and is not restarted by a write.

Other behaviour can only be shown by the bench scenarios:
- The exact period for every setting 0 to 255.
- The byte and bit positions seen on the bus.
- The summary dropping only after the overrun is cleared.
- The full transmit word for every low byte.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TXL = 3'd0,
    REG_TXH = 3'd1,
    REG_RXL = 3'd2,
    REG_RXH = 3'd3,
    REG_DIV = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic sum;
    logic per;
    logic fer;
    logic oer;
  } rx_err_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [7:0]        wdata_i,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HI_W = DATA_W - 8;

  logic [HI_W-1:0]   hi_q;
  logic              armed_q;
  logic              load_q;
  logic [DATA_W-1:0] data_q;
  logic              commit;

  assign commit = wr_lo_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      armed_q <= 1'b0;
      load_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      load_q <= commit;
      if (wr_hi_i) begin
        hi_q    <= wdata_i[HI_W-1:0];
        armed_q <= 1'b1;
      end else if (commit) begin
        armed_q <= 1'b0;
        data_q  <= {hi_q, wdata_i};
      end
    end
  end

  assign load_o = load_q;
  assign data_o = data_q;

  a_r4_lone_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !armed_q) |=> !load_q);
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q);
  a_r3_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> $stable(data_q));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int unsigned DATA_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_off_i,
  input  logic                    rd_hi_i,
  input  logic                    done_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    fer_i,
  input  logic                    per_i,
  output logic [DATA_W-1:0]       data_o,
  output uart_front_pkg::rx_err_t err_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, oer_q, fer_q, per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      oer_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else if (rx_off_i) begin
      full_q <= 1'b0;
      oer_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      if (rd_hi_i) begin
        full_q <= 1'b0;
        fer_q  <= 1'b0;
        per_q  <= 1'b0;
      end
      if (done_i) begin
        if (full_q && !rd_hi_i) begin
          oer_q <= 1'b1;
        end else begin
          data_q <= data_i;
          fer_q  <= fer_i;
          per_q  <= per_i;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign data_o = data_q;
  assign err_o  = '{sum: oer_q | fer_q | per_q, per: per_q, fer: fer_q, oer: oer_q};

  a_r10_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_off_i |=> (!oer_q && !fer_q && !per_q));
  a_r8_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_off_i && done_i && full_q && !rd_hi_i) |=> (oer_q && $stable(data_q)));
  a_r7_hi_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_off_i && rd_hi_i && !done_i) |=> (!fer_q && !per_q && $stable(oer_q)));
endmodule

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] n_i,
  output logic [DIV_W-1:0] n_o,
  output logic             en_o
);
  logic [DIV_W-1:0] n_q, cnt_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_i) n_q <= n_i;
      en_q <= (cnt_q == '0);
      // reload uses the setting held before this edge
      if (cnt_q == '0) cnt_q <= n_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign n_o  = n_q;
  assign en_o = en_q;

  a_r1_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && cnt_q != '0) |=> !en_q);
  a_r2_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned MODE_W = 3
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [uart_front_pkg::ADDR_W-1:0]   addr_i,
  input  logic                                wr_i,
  input  logic                                rd_i,
  input  logic [7:0]                          wdata_i,
  output logic [7:0]                          rdata_o,
  input  logic [MODE_W-1:0]                   mode_i,
  input  logic                                rx_en_i,
  input  logic                                rx_done_i,
  input  logic [DATA_W-1:0]                   rx_data_i,
  input  logic                                rx_fer_i,
  input  logic                                rx_per_i,
  output logic                                tx_load_o,
  output logic [DATA_W-1:0]                   tx_data_o,
  output logic                                baud_en_o
);
  import uart_front_pkg::*;

  localparam int unsigned HI_W  = DATA_W - 8;
  localparam int unsigned PAD_W = 4 - HI_W;

  reg_sel_e          sel;
  logic              rx_off;
  logic [DATA_W-1:0] rx_word;
  rx_err_t           rx_err;
  logic [DIV_W-1:0]  div_n;

  assign sel    = reg_sel_e'(addr_i);
  assign rx_off = (mode_i == '0) || !rx_en_i;

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_i && sel == REG_TXL),
    .wr_hi_i (wr_i && sel == REG_TXH),
    .wdata_i (wdata_i),
    .load_o  (tx_load_o),
    .data_o  (tx_data_o)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_off_i (rx_off),
    .rd_hi_i  (rd_i && sel == REG_RXH),
    .done_i   (rx_done_i),
    .data_i   (rx_data_i),
    .fer_i    (rx_fer_i),
    .per_i    (rx_per_i),
    .data_o   (rx_word),
    .err_o    (rx_err)
  );

  uart_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i && sel == REG_DIV),
    .n_i    (wdata_i[DIV_W-1:0]),
    .n_o    (div_n),
    .en_o   (baud_en_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        REG_RXL: rdata_o = rx_word[7:0];
        REG_RXH: rdata_o = {rx_err, {PAD_W{1'b0}}, rx_word[DATA_W-1:8]};
        REG_DIV: rdata_o = 8'(div_n);
        default: rdata_o = '0;
      endcase
    end
  end

  a_r10_status_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_off && rd_i && sel == REG_RXH) |-> (rdata_o[7:4] == 4'h0));
endmodule

// File: tb/uart_reg_front_tb.sv
module uart_reg_front_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] mode = 3'b001;
  logic       rx_en = 1'b1;
  logic       rx_done = 1'b0;
  logic [8:0] rx_data = '0;
  logic       rx_fer = 1'b0, rx_per = 1'b0;
  logic       tx_load;
  logic [8:0] tx_data;
  logic       baud_en;

  int total = 0, bad = 0;
  int cyc = 0;
  int tx_cnt = 0;
  logic [8:0] tx_last = '0;

  always #2 clk = ~clk;

  uart_reg_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .mode_i(mode), .rx_en_i(rx_en),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_fer_i(rx_fer), .rx_per_i(rx_per),
    .tx_load_o(tx_load), .tx_data_o(tx_data), .baud_en_o(baud_en)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (tx_load) begin tx_cnt++; tx_last = tx_data; end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic rx_strobe(input logic [8:0] d, input logic f, input logic p);
    @(negedge clk); rx_data = d; rx_fer = f; rx_per = p; rx_done = 1'b1;
    @(posedge clk); #1 rx_done = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!baud_en);
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p0, p1, p2, p3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    bus_read(3'd3, d); chk("R11 status after reset", d, 8'h00);
    bus_read(3'd4, d); chk("R11 divider after reset", d, 8'h00);
    chk("R11 no tx load", tx_cnt, 0);

    // R4 lone low byte write
    bus_write(3'd0, 8'h5A); settle();
    chk("R4 lone low write", tx_cnt, 0);
    // R3 paired write
    bus_write(3'd1, 8'h01); bus_write(3'd0, 8'h34); settle();
    chk("R3 one load", tx_cnt, 1);
    chk("R3 tx word", tx_last, 9'h134);
    bus_write(3'd0, 8'h77); settle();
    chk("R4 low after commit", tx_cnt, 1);
    // R3 sweep of all low bytes, high bit alternating; only bit 0 of high kept
    for (int lo = 0; lo < 256; lo++) begin
      logic [7:0] hb;
      hb = (lo[0]) ? 8'hFE : 8'h03;
      bus_write(3'd1, hb); bus_write(3'd0, 8'(lo)); settle();
      chk("R3 sweep word", tx_last, {hb[0], 8'(lo)});
    end
    chk("R3 sweep count", tx_cnt, 257);

    // R5 / R6 layout
    rx_strobe(9'h1A5, 1'b0, 1'b0);
    bus_read(3'd2, d); chk("R5 low byte", d, 8'hA5);
    bus_read(3'd3, d); chk("R5 high byte", d, 8'h01);
    rx_strobe(9'h03C, 1'b1, 1'b0);
    bus_read(3'd3, d); chk("R6 framing bit", d, 8'hA0);
    bus_read(3'd3, d); chk("R7 framing cleared", d, 8'h00);
    rx_strobe(9'h111, 1'b0, 1'b1);
    bus_read(3'd3, d); chk("R6 parity bit", d, 8'hC1);
    bus_read(3'd3, d); chk("R7 parity cleared", d, 8'h01);

    // R8 overrun
    rx_strobe(9'h055, 1'b0, 1'b0);
    rx_strobe(9'h1FF, 1'b1, 1'b1);
    bus_read(3'd2, d); chk("R8 old data kept", d, 8'h55);
    bus_read(3'd3, d); chk("R8 overrun flag", d, 8'h90);
    bus_read(3'd3, d); chk("R7 overrun survives read", d, 8'h90);
    rx_strobe(9'h0AA, 1'b0, 1'b1);
    bus_read(3'd3, d); chk("R9 summary with two flags", d, 8'hD0);
    bus_read(3'd3, d); chk("R9 summary held by overrun", d, 8'h90);

    // R10 receiver disable
    @(negedge clk); rx_en = 1'b0;
    bus_read(3'd3, d); chk("R10 flags clear rx off", d, 8'h00);
    rx_strobe(9'h1EE, 1'b1, 1'b1);
    @(negedge clk); rx_en = 1'b1;
    bus_read(3'd3, d); chk("R10 strobe ignored flags", d, 8'h00);
    bus_read(3'd2, d); chk("R10 strobe ignored data", d, 8'hAA);
    rx_strobe(9'h000, 1'b1, 1'b0);
    @(negedge clk); mode = 3'b000;
    @(negedge clk); mode = 3'b001;
    bus_read(3'd3, d); chk("R10 mode 000 clears", d, 8'h00);

    // R2 write does not restart count
    bus_write(3'd4, 8'd9);
    wait_pulse(p0); wait_pulse(p1); wait_pulse(p2);
    chk("R1 period n=9", p2 - p1, 10);
    bus_write(3'd4, 8'd0);
    wait_pulse(p3);
    chk("R2 old schedule kept", p3 - p2, 10);
    wait_pulse(p1);
    chk("R2 new period applies", p1 - p3, 1);

    // R1 sweep all settings
    for (int n = 0; n < 256; n++) begin
      bus_write(3'd4, 8'(n));
      wait_pulse(p0); wait_pulse(p1); wait_pulse(p2);
      chk("R1 divider period", p2 - p1, n + 1);
    end
    bus_read(3'd4, d); chk("R1 divider readback", d, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule